// File: doc/BRIEF.md
# Conversion Start and Busy Sequencer

This block paces a sampling converter through its acquire, hold and convert cycle. After reset, or once the previous result has been taken, it spends a fixed number of clocks acquiring. It then looks at the conversion-start input. If that input is low, conversion begins at once. If it is high, the block holds off until the input falls. The conversion takes a fixed number of clocks, with busy held high. In the last busy cycle the block pulses a load strobe toward the output shift register. That same clock edge captures the supplied sample into the result register. In the first cycle after busy drops, a one-cycle ready strobe marks the new result as valid, and the next acquisition starts in that same cycle.

Power-down stops new conversions from being launched, but a conversion already under way always runs to completion. A high reset aborts everything and returns the block to acquisition, with busy low and no ready strobe.

The states are ACQUIRE, WAIT_START, CONVERT, LATCH and POWERDOWN. The transitions are:

- ACQUIRE to POWERDOWN, when power-down is high.
- ACQUIRE to CONVERT, on the last acquisition cycle when the synchronised start level is low.
- ACQUIRE to WAIT_START, on the last acquisition cycle when the synchronised start level is high.
- WAIT_START to POWERDOWN, when power-down is high.
- WAIT_START to CONVERT, on a synchronised falling edge of start.
- CONVERT to LATCH, on the last conversion cycle.
- LATCH to ACQUIRE, always.
- POWERDOWN to ACQUIRE, when power-down is low.

Top module: `conv_seq_top`

## Requirements
- R1: While reset is high and in the first cycle after it is released, busy_o, load_o and ready_o are low and result_o is zero.
- R2: Acquisition lasts ACQ_CYCLES clocks. With start_i held low, busy_o first reads high ACQ_CYCLES rising edges after reset is released.
- R3: If the synchronised start level is low on the last acquisition cycle, busy_o rises on the very next edge, with no wait for any edge of start_i.
- R4: If start_i is high when acquisition ends, busy_o stays low until start_i falls. After start_i goes low between two edges, busy_o reads high after the third rising edge. Two of those edges are spent in the two-flop synchroniser and one in the state change.
- R5: busy_o stays high for exactly CONV_CYCLES+1 cycles. load_o is high only in the last of those cycles.
- R6: In the first cycle with busy_o low after a conversion, ready_o is high for exactly one cycle. result_o then equals the value sample_i had in the load_o cycle, and result_o changes at no other time.
- R7: A high reset during a conversion drops busy_o, and no ready_o strobe is issued for the aborted conversion.
- R8: While pwrdn_i is high and busy_o is low, busy_o stays low. After pwrdn_i falls with start_i low, busy_o rises ACQ_CYCLES+1 edges later.
- R9: pwrdn_i rising during a conversion neither shortens busy_o nor suppresses ready_o.
- R10: Edges on start_i while busy_o is high have no effect on the busy length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous active-high reset; aborts any conversion |
| start_i | input | 1 | Asynchronous conversion-start request |
| pwrdn_i | input | 1 | Power-down request, synchronous to clk_i |
| sample_i | input | SAMPLE_W | Digitised value captured at the end of a conversion |
| busy_o | output | 1 | High from the start of conversion until the result is latched |
| load_o | output | 1 | One-cycle strobe, in the last busy cycle, to load the output shift register |
| ready_o | output | 1 | One-cycle result-valid strobe, in the cycle busy first reads low |
| result_o | output | SAMPLE_W | Latched conversion result |

## Verification
busy_o is a Moore output and goes high on the edge that leaves acquisition. That is ACQ_CYCLES edges after reset release, or three edges after a low-going start_i that has to pass the synchroniser. It then stays high for CONV_CYCLES+1 edges. ready_o and the new result_o appear on the same edge that drops busy_o.

The bench drives inputs on falling edges and advances a behavioural model on each rising edge. It compares all outputs 1 ns after that edge, so each expected value is read in the first cycle it is due. The scenario checks count rising edges from a stimulus to a change on busy_o and compare that count with the figures above.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [2:0] {
        ST_ACQUIRE    = 3'd0,
        ST_WAIT_START = 3'd1,
        ST_CONVERT    = 3'd2,
        ST_LATCH      = 3'd3,
        ST_POWERDOWN  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/cs_start_sync.sv
module cs_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic level_o,
    output logic fall_o
);
    // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous level
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], start_i};
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/cs_phase_timer.sv
module cs_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clr_i,
    input  logic [CW-1:0] limit_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == (limit_i - 1'b1));

endmodule

// File: rtl/cs_fsm.sv
module cs_fsm
    import conv_seq_pkg::*;
#(
    parameter int ACQ_CYCLES  = 8,
    parameter int CONV_CYCLES = 12,
    parameter int CW          = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          level_i,
    input  logic          fall_i,
    input  logic          pwrdn_i,
    input  logic          last_i,
    output logic          clr_o,
    output logic [CW-1:0] limit_o,
    output logic          busy_o,
    output logic          load_o
);
    seq_state_t state_q;
    seq_state_t state_n;

    // state register
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= ST_ACQUIRE;
        end else begin
            state_q <= state_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_ACQUIRE: begin
                if (pwrdn_i) begin
                    state_n = ST_POWERDOWN;
                end else if (last_i) begin
                    state_n = level_i ? ST_WAIT_START : ST_CONVERT;
                end
            end
            ST_WAIT_START: begin
                if (pwrdn_i) begin
                    state_n = ST_POWERDOWN;
                end else if (fall_i) begin
                    state_n = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (last_i) begin
                    state_n = ST_LATCH;
                end
            end
            ST_LATCH: begin
                state_n = ST_ACQUIRE;
            end
            ST_POWERDOWN: begin
                if (!pwrdn_i) begin
                    state_n = ST_ACQUIRE;
                end
            end
            default: begin
                state_n = ST_ACQUIRE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy_o  = 1'b0;
        load_o  = 1'b0;
        limit_o = CW'(CONV_CYCLES);
        clr_o   = (state_n != state_q);
        unique case (state_q)
            ST_ACQUIRE: begin
                limit_o = CW'(ACQ_CYCLES);
            end
            ST_WAIT_START: begin
                limit_o = CW'(ACQ_CYCLES);
            end
            ST_CONVERT: begin
                busy_o = 1'b1;
            end
            ST_LATCH: begin
                busy_o = 1'b1;
                load_o = 1'b1;
            end
            ST_POWERDOWN: begin
                limit_o = CW'(ACQ_CYCLES);
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cs_result_reg.sv
module cs_result_reg #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                load_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SAMPLE_W-1:0] data_o,
    output logic                valid_o
);
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) begin
                data_o <= sample_i;
            end
        end
    end

endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top #(
    parameter int ACQ_CYCLES  = 8,
    parameter int CONV_CYCLES = 12,
    parameter int SAMPLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                start_i,
    input  logic                pwrdn_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                busy_o,
    output logic                load_o,
    output logic                ready_o,
    output logic [SAMPLE_W-1:0] result_o
);
    localparam int MAX_LEN = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic          start_level;
    logic          start_fall;
    logic          timer_clr;
    logic          timer_last;
    logic [CW-1:0] timer_limit;

    cs_start_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .level_o (start_level),
        .fall_o  (start_fall)
    );

    cs_phase_timer #(.CW(CW)) i_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (timer_clr),
        .limit_i (timer_limit),
        .last_o  (timer_last)
    );

    cs_fsm #(
        .ACQ_CYCLES  (ACQ_CYCLES),
        .CONV_CYCLES (CONV_CYCLES),
        .CW          (CW)
    ) i_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (start_level),
        .fall_i  (start_fall),
        .pwrdn_i (pwrdn_i),
        .last_i  (timer_last),
        .clr_o   (timer_clr),
        .limit_o (timer_limit),
        .busy_o  (busy_o),
        .load_o  (load_o)
    );

    cs_result_reg #(.SAMPLE_W(SAMPLE_W)) i_result (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (load_o),
        .sample_i (sample_i),
        .data_o   (result_o),
        .valid_o  (ready_o)
    );

endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
    parameter int CONV_CYCLES = 12,
    parameter int SAMPLE_W    = 16
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                pwrdn_i,
    input logic [SAMPLE_W-1:0] sample_i,
    input logic                busy_o,
    input logic                load_o,
    input logic                ready_o,
    input logic [SAMPLE_W-1:0] result_o
);
    logic [31:0] run_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= '0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        rst_i |=> (!busy_o && !ready_o));

    // R5
    busy_length_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> (run_q == 32'(CONV_CYCLES + 1)));

    // R5
    load_ends_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_o |=> !busy_o);

    // R6
    ready_follows_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> (!busy_o && $past(busy_o)));

    // R6
    ready_on_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> ready_o);

    // R6
    result_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> (result_o == $past(sample_i)));

    // R6
    result_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !ready_o |-> $stable(result_o));

    // R8
    pwrdn_block_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pwrdn_i && !busy_o) |=> !busy_o);

    // R9
    busy_holds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !load_o) |=> busy_o);

endmodule

bind conv_seq_top conv_seq_chk #(
    .CONV_CYCLES (CONV_CYCLES),
    .SAMPLE_W    (SAMPLE_W)
) i_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .pwrdn_i  (pwrdn_i),
    .sample_i (sample_i),
    .busy_o   (busy_o),
    .load_o   (load_o),
    .ready_o  (ready_o),
    .result_o (result_o)
);

// File: tb/test_conv_seq_top.sv
module test_conv_seq_top;
    localparam int ACQ  = 8;
    localparam int CONV = 12;
    localparam int W    = 16;

    localparam int P_ACQ  = 0;
    localparam int P_WAIT = 1;
    localparam int P_CONV = 2;
    localparam int P_LOAD = 3;
    localparam int P_OFF  = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         pd = 1'b0;
    logic [W-1:0] sample = '0;
    logic         busy;
    logic         load;
    logic         ready;
    logic [W-1:0] result;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    conv_seq_top #(
        .ACQ_CYCLES  (ACQ),
        .CONV_CYCLES (CONV),
        .SAMPLE_W    (W)
    ) i_conv_seq_top (
        .clk_i    (clk),
        .rst_i    (rst),
        .start_i  (start),
        .pwrdn_i  (pd),
        .sample_i (sample),
        .busy_o   (busy),
        .load_o   (load),
        .ready_o  (ready),
        .result_o (result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: a start-sample delay queue and a remaining-cycle count
    int       ph = P_ACQ;
    int       left = ACQ;
    bit       pipe[$] = '{0, 0, 0};
    bit       e_busy = 0, e_load = 0, e_ready = 0;
    int       e_res = 0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            ph = P_ACQ; left = ACQ; pipe = '{0, 0, 0};
            e_ready = 0; e_res = 0;
        end else begin
            bit lvl;
            bit fell;
            lvl  = pipe[1];
            fell = pipe[2] && !pipe[1];
            e_ready = (ph == P_LOAD);
            if (ph == P_LOAD) e_res = int'(sample);
            case (ph)
                P_ACQ:  if (pd) ph = P_OFF;
                        else if (left == 1) begin ph = lvl ? P_WAIT : P_CONV; left = CONV; end
                        else left--;
                P_WAIT: if (pd) ph = P_OFF;
                        else if (fell) begin ph = P_CONV; left = CONV; end
                P_CONV: if (left == 1) ph = P_LOAD; else left--;
                P_LOAD: begin ph = P_ACQ; left = ACQ; end
                default: if (!pd) begin ph = P_ACQ; left = ACQ; end
            endcase
            if (ph == P_OFF) left = ACQ;
            pipe.push_front(start);
            void'(pipe.pop_back());
        end
        e_busy = (ph == P_CONV) || (ph == P_LOAD);
        e_load = (ph == P_LOAD);
        #1;
        if (!done) begin
            chk(busy == e_busy, "R5 busy vs model", int'(busy), int'(e_busy));
            chk(load == e_load, "R5 load vs model", int'(load), int'(e_load));
            chk(ready == e_ready, "R6 ready vs model", int'(ready), int'(e_ready));
            chk(int'(result) == e_res, "R6 result vs model", int'(result), e_res);
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic edges_until(input bit want, output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (busy != want && n < 500);
    endtask

    initial begin
        int n;
        int k;
        bit ok;
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !load && !ready && result == 0, "R1 reset state", int'(busy), 0);
        sample = 16'hA5C3;
        rst = 1'b0;
        @(posedge clk); #1;
        chk(!busy && !ready && result == 0, "R1 first cycle after release", int'(ready), 0);
        edges_until(1'b1, n);
        // R2 / R3: start low, one edge already passed
        chk(n + 1 == ACQ, "R2 acquisition length", n + 1, ACQ);
        chk(busy, "R3 immediate start with low level", int'(busy), 1);
        edges_until(1'b0, n);
        chk(n == CONV + 1, "R5 busy length", n, CONV + 1);
        chk(ready, "R6 ready on busy fall", int'(ready), 1);
        chk(result == 16'hA5C3, "R6 result value", int'(result), 16'hA5C3);

        // R4: start high through acquisition
        @(negedge clk) start = 1'b1;
        sample = 16'h3C5A;
        repeat (20) @(posedge clk);
        #1;
        chk(!busy, "R4 waits while start high", int'(busy), 0);
        @(negedge clk) start = 1'b0;
        edges_until(1'b1, n);
        chk(n == 3, "R4 falling edge latency", n, 3);
        // R10: start toggles during conversion
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        edges_until(1'b0, k);
        chk(k + 1 == CONV + 1, "R10 busy length with start activity", k + 1, CONV + 1);
        chk(result == 16'h3C5A, "R6 second result", int'(result), 16'h3C5A);

        // R8: power-down while idle
        @(negedge clk) pd = 1'b1;
        ok = 1;
        repeat (30) begin
            @(posedge clk); #1;
            if (busy) ok = 0;
        end
        chk(ok, "R8 no conversion while powered down", int'(ok), 1);
        @(negedge clk) pd = 1'b0;
        sample = 16'h0F0F;
        edges_until(1'b1, n);
        chk(n == ACQ + 1, "R8 restart after power-down", n, ACQ + 1);

        // R9: power-down during conversion
        repeat (3) @(posedge clk);
        @(negedge clk) pd = 1'b1;
        edges_until(1'b0, k);
        chk(k + 3 == CONV + 1, "R9 conversion completes", k + 3, CONV + 1);
        chk(ready && result == 16'h0F0F, "R9 result delivered", int'(result), 16'h0F0F);
        ok = 1;
        repeat (20) begin
            @(posedge clk); #1;
            if (busy) ok = 0;
        end
        chk(ok, "R9 no new conversion after deferred power-down", int'(ok), 1);
        @(negedge clk) pd = 1'b0;
        sample = 16'h1234;

        // R7: abort by reset
        edges_until(1'b1, n);
        chk(n == ACQ + 1, "R7 conversion started", n, ACQ + 1);
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        chk(!busy && !ready && result == 0, "R7 abort clears busy", int'(busy), 0);
        @(negedge clk) rst = 1'b0;
        ok = 1;
        repeat (ACQ - 1) begin
            @(posedge clk); #1;
            if (ready || busy) ok = 0;
        end
        chk(ok, "R7 no strobe after abort", int'(ok), 1);
        edges_until(1'b0, n);
        edges_until(1'b0, n);
        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule